// File: doc/BRIEF.md
# Two-Master Coherency Hub

This block sits on the slave side of a coherent memory system shared by two caching masters. Each master sends read-type commands (shared read, unique read, untracked one-shot read, upgrade to unique, read barrier) and write-type commands (write-back with invalidate, write-back keeping a shared copy, write-back keeping a unique copy, clean eviction, write barrier). The hub keeps a small table that records, for every memory line and every master, whether that master holds a valid copy, whether the copy is unique, and whether it is the owner. An internal array of line-sized words backs the memory.

When a read needs the other master's copy to change, the hub sends that master a probe (invalidate or downgrade to shared) and waits. The probed master either acknowledges the probe or returns the line with a write tagged with the probe's identifier. A tagged write lands in memory before the read is answered, so dirty data taken from an owner is never lost. The requester then gets its response with the granted state. The hub then holds every new command until the requester acknowledges that response. Commands are handled one at a time. When both kinds are waiting, writes go before reads, and master 0 goes before master 1.

Top module: `coh_hub`

## Requirements
- R1: After reset no response, probe or ready is asserted while no command is valid, every line is held by no master, and every backing word reads as zero.
- R2: A shared read (read op 0) of a line that no other master holds sends no probe. It answers, on the cycle after acceptance, with kind data (kind 2), the line's memory word, unique=1, owner=1 and dirty=0.
- R3: A shared read of a line that the other master holds as unique or owner first sends that master a downgrade probe (probe op 1) with the line address. No read response appears before the probe completes. If the other master still holds a copy afterwards, the grant is unique=0, owner=0.
- R4: A unique read (read op 1) or an upgrade (read op 3) of a line that the other master holds sends an invalidate probe (probe op 0). A unique read answers with data, unique=1 and owner=1. An upgrade answers with kind success (kind 0).
- R5: During a probe, the only write accepted is a write-invalidate (write op 0) or write-share (write op 1) from the probed master that carries the probe's identifier. It answers writeSuccess on the next cycle and completes the probe. Its data is what the following read response returns. A write with any other identifier stays stalled.
- R6: Data reads (read ops 0, 1, 2) whose address is MEM_LINES or higher answer kind error (kind 1). Writes to such addresses still answer writeSuccess.
- R7: Every accepted write command answers with a one-cycle wr_rsp_valid pulse for its master on the next cycle. Write ops 0 to 2 store their data into the line. An eviction (write op 3) or write-invalidate clears the sender's copy, so a later shared read from the other master needs no probe.
- R8: A read barrier (read op 4) answers kind success, and a write barrier (write op 4) answers writeSuccess. Neither changes any line.
- R9: When write and read commands are pending together while the hub is idle, a write is accepted first. Within one kind, master 0 is accepted before master 1.
- R10: From a read response until the requester's read acknowledge, no read or write command from either master is accepted.
- R11: A one-shot read (read op 2) returns the memory word with unique=0 and owner=0 and records no copy, so a later shared read from the other master is granted unique without a probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_cmd_valid | input | 2 | Read command valid, one bit per master |
| rd_cmd_ready | output | 2 | Read command accepted, one bit per master |
| rd_cmd_op | input | 6 | Read op, 3 bits per master (master 0 in bits 2:0) |
| rd_cmd_addr | input | 2*AW | Line address, AW bits per master |
| rd_rsp_valid | output | 2 | One-cycle read response pulse, one bit per master |
| rd_rsp_kind | output | 2 | 0 success, 1 error, 2 data |
| rd_rsp_data | output | DW | Line word for data responses |
| rd_rsp_unique | output | 1 | Granted copy is unique |
| rd_rsp_owner | output | 1 | Granted copy is owner |
| rd_rsp_dirty | output | 1 | Granted copy is dirty (always clean) |
| rd_ack_valid | input | 2 | Read response acknowledge, one bit per master |
| wr_cmd_valid | input | 2 | Write command valid, one bit per master |
| wr_cmd_ready | output | 2 | Write command accepted, one bit per master |
| wr_cmd_op | input | 6 | Write op, 3 bits per master |
| wr_cmd_addr | input | 2*AW | Line address, AW bits per master |
| wr_cmd_data | input | 2*DW | Write data, DW bits per master |
| wr_cmd_id | input | 2*IDW | Probe identifier carried by probe-induced writes |
| wr_rsp_valid | output | 2 | One-cycle writeSuccess pulse, one bit per master |
| probe_cmd_valid | output | 2 | Probe request, one bit per target master |
| probe_cmd_ready | input | 2 | Probe taken by the target master |
| probe_cmd_op | output | 1 | 0 invalidate, 1 downgrade to shared |
| probe_cmd_addr | output | AW | Probed line |
| probe_cmd_id | output | IDW | Identifier the answering write must carry |
| probe_rsp_valid | input | 2 | Probe acknowledged without data, one bit per master |

## Verification
The assertions assume that masters follow the coherence rules. A master that holds a dirty line answers a probe with a tagged write rather than a bare acknowledge. Acknowledges and probe-answer writes come only while a response or probe is outstanding for that master. Upgrades come only from a master that holds a shared copy. The directed scenarios keep to this: each probe is answered by the probed master once, either with an acknowledge or with a write carrying the captured identifier. The only write sent with a wrong identifier is sent on purpose, and it is withdrawn before the real answer.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    RD_SHARED  = 3'd0,
    RD_UNIQUE  = 3'd1,
    RD_ONCE    = 3'd2,
    RD_MKUNIQ  = 3'd3,
    RD_BARRIER = 3'd4
  } rd_op_e;

  typedef enum logic [2:0] {
    WR_INVAL   = 3'd0,
    WR_SHARE   = 3'd1,
    WR_UNIQ    = 3'd2,
    WR_EVICT   = 3'd3,
    WR_BARRIER = 3'd4
  } wr_op_e;

  typedef enum logic [1:0] {
    RSP_OK   = 2'd0,
    RSP_ERR  = 2'd1,
    RSP_DATA = 2'd2
  } rsp_kind_e;

  localparam logic PRB_INVAL = 1'b0;
  localparam logic PRB_SHARE = 1'b1;

  typedef struct packed {
    logic valid;
    logic uniq;
    logic owner;
  } hold_t;

  typedef enum logic [2:0] {
    S_IDLE, S_WRSP, S_PROBE, S_PWAIT, S_PWRSP, S_RRSP, S_ACKW
  } hub_st_e;

  function automatic hold_t mk_hold(input logic v, input logic u, input logic o);
    hold_t h;
    h.valid = v;
    h.uniq  = u;
    h.owner = o;
    return h;
  endfunction

endpackage

// File: rtl/coh_rst_sync.sv
module coh_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/coh_arb.sv
module coh_arb #(
  parameter int NM = 2,
  localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic          en,
  input  logic [NM-1:0] wr_req,
  input  logic [NM-1:0] rd_req,
  output logic          gnt_wr,
  output logic          gnt_rd,
  output logic [MW-1:0] gnt_idx
);
  // Fixed order: any write beats any read, lower index wins within a kind.
  always_comb begin
    gnt_wr  = 1'b0;
    gnt_rd  = 1'b0;
    gnt_idx = '0;
    if (en) begin
      if (|wr_req) begin
        gnt_wr = 1'b1;
        for (int i = NM - 1; i >= 0; i--) begin
          if (wr_req[i]) gnt_idx = MW'(i);
        end
      end else if (|rd_req) begin
        gnt_rd = 1'b1;
        for (int i = NM - 1; i >= 0; i--) begin
          if (rd_req[i]) gnt_idx = MW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/coh_line_table.sv
module coh_line_table
  import coh_pkg::*;
#(
  parameter int LINES = 12,
  parameter int AW    = 4,
  parameter int NM    = 2,
  localparam int MW   = (NM > 1) ? $clog2(NM) : 1,
  localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       rd_addr,
  output hold_t [NM-1:0]      rd_hold,
  input  logic                we,
  input  logic [AW-1:0]       wr_addr,
  input  logic [MW-1:0]       wr_m,
  input  hold_t               wr_val
);
  localparam logic [AW:0] LIM = (AW+1)'(LINES);

  hold_t tbl_q [LINES][NM];
  logic  rd_in, wr_in;

  assign rd_in = {1'b0, rd_addr} < LIM;
  assign wr_in = {1'b0, wr_addr} < LIM;

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      rd_hold[m] = rd_in ? tbl_q[rd_addr[LW-1:0]][m] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) begin
        for (int m = 0; m < NM; m++) tbl_q[l][m] <= '0;
      end
    end else if (we && wr_in) begin
      tbl_q[wr_addr[LW-1:0]][wr_m] <= wr_val;
    end
  end
endmodule

// File: rtl/coh_store.sv
module coh_store #(
  parameter int LINES = 12,
  parameter int AW    = 4,
  parameter int DW    = 16,
  localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam logic [AW:0] LIM = (AW+1)'(LINES);

  logic [DW-1:0] mem_q [LINES];
  logic          rd_in, wr_in;

  assign rd_in   = {1'b0, rd_addr} < LIM;
  assign wr_in   = {1'b0, wr_addr} < LIM;
  assign rd_data = rd_in ? mem_q[rd_addr[LW-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) mem_q[l] <= '0;
    end else if (we && wr_in) begin
      mem_q[wr_addr[LW-1:0]] <= wr_data;
    end
  end
endmodule

// File: rtl/coh_hub.sv
module coh_hub
  import coh_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DW        = 16,
  parameter int MEM_LINES = 12,
  parameter int IDW       = 3
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic [1:0]      rd_cmd_valid,
  output logic [1:0]      rd_cmd_ready,
  input  logic [5:0]      rd_cmd_op,
  input  logic [2*AW-1:0] rd_cmd_addr,
  output logic [1:0]      rd_rsp_valid,
  output logic [1:0]      rd_rsp_kind,
  output logic [DW-1:0]   rd_rsp_data,
  output logic            rd_rsp_unique,
  output logic            rd_rsp_owner,
  output logic            rd_rsp_dirty,
  input  logic [1:0]      rd_ack_valid,
  input  logic [1:0]      wr_cmd_valid,
  output logic [1:0]      wr_cmd_ready,
  input  logic [5:0]      wr_cmd_op,
  input  logic [2*AW-1:0] wr_cmd_addr,
  input  logic [2*DW-1:0] wr_cmd_data,
  input  logic [2*IDW-1:0] wr_cmd_id,
  output logic [1:0]      wr_rsp_valid,
  output logic [1:0]      probe_cmd_valid,
  input  logic [1:0]      probe_cmd_ready,
  output logic            probe_cmd_op,
  output logic [AW-1:0]   probe_cmd_addr,
  output logic [IDW-1:0]  probe_cmd_id,
  input  logic [1:0]      probe_rsp_valid
);
  localparam int NM = 2;
  localparam logic [AW:0] LIM = (AW+1)'(MEM_LINES);

  logic rst_n;
  coh_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  // Per-master views of the flattened command buses.
  rd_op_e          rd_op_a   [NM];
  wr_op_e          wr_op_a   [NM];
  logic [AW-1:0]   rd_addr_a [NM];
  logic [AW-1:0]   wr_addr_a [NM];
  logic [DW-1:0]   wr_data_a [NM];
  logic [IDW-1:0]  wr_id_a   [NM];

  always_comb begin
    for (int i = 0; i < NM; i++) begin
      rd_op_a[i]   = rd_op_e'(rd_cmd_op[3*i +: 3]);
      wr_op_a[i]   = wr_op_e'(wr_cmd_op[3*i +: 3]);
      rd_addr_a[i] = rd_cmd_addr[AW*i +: AW];
      wr_addr_a[i] = wr_cmd_addr[AW*i +: AW];
      wr_data_a[i] = wr_cmd_data[DW*i +: DW];
      wr_id_a[i]   = wr_cmd_id[IDW*i +: IDW];
    end
  end

  // State registers and their next values.
  hub_st_e        st_q, st_nx;
  logic           req_m_q;
  rd_op_e         req_op_q;
  logic [AW-1:0]  req_addr_q;
  logic           prb_op_q, prb_op_nx;
  logic [IDW-1:0] prb_id_q, prb_id_nx;
  logic           load_req;

  logic idle, gnt_wr, gnt_rd, gnt_m;
  assign idle = (st_q == S_IDLE);

  coh_arb #(.NM(NM)) u_arb (
    .en(idle), .wr_req(wr_cmd_valid), .rd_req(rd_cmd_valid),
    .gnt_wr(gnt_wr), .gnt_rd(gnt_rd), .gnt_idx(gnt_m)
  );

  logic          cur_m, oth_m;
  logic [AW-1:0] look_addr;
  logic          look_bad;
  hold_t [NM-1:0] hold;

  assign cur_m     = idle ? gnt_m : req_m_q;
  assign oth_m     = ~cur_m;
  assign look_addr = !idle ? req_addr_q : (gnt_wr ? wr_addr_a[gnt_m] : rd_addr_a[gnt_m]);
  assign look_bad  = ({1'b0, look_addr} >= LIM);

  logic          t_we, t_m;
  hold_t         t_val;
  logic          m_we;
  logic [DW-1:0] m_data, m_rd;

  coh_line_table #(.LINES(MEM_LINES), .AW(AW), .NM(NM)) u_tbl (
    .clk(clk), .rst_n(rst_n), .rd_addr(look_addr), .rd_hold(hold),
    .we(t_we), .wr_addr(look_addr), .wr_m(t_m), .wr_val(t_val)
  );

  coh_store #(.LINES(MEM_LINES), .AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_addr(look_addr), .rd_data(m_rd),
    .we(m_we), .wr_addr(look_addr), .wr_data(m_data)
  );

  logic pw_match;
  assign pw_match = wr_cmd_valid[oth_m] && (wr_id_a[oth_m] == prb_id_q) &&
                    ((wr_op_a[oth_m] == WR_INVAL) || (wr_op_a[oth_m] == WR_SHARE));

  // Next-state, table and memory write decisions.
  always_comb begin
    st_nx        = st_q;
    load_req     = 1'b0;
    prb_op_nx    = prb_op_q;
    prb_id_nx    = prb_id_q;
    t_we         = 1'b0;
    t_m          = cur_m;
    t_val        = '0;
    m_we         = 1'b0;
    m_data       = wr_data_a[cur_m];
    rd_cmd_ready = '0;
    wr_cmd_ready = '0;
    case (st_q)
      S_IDLE: begin
        if (gnt_wr) begin
          wr_cmd_ready[gnt_m] = 1'b1;
          load_req = 1'b1;
          st_nx    = S_WRSP;
          if (!look_bad) begin
            case (wr_op_a[gnt_m])
              WR_INVAL: begin m_we = 1'b1; t_we = 1'b1; t_val = '0; end
              WR_SHARE: begin
                m_we = 1'b1; t_we = 1'b1;
                t_val = mk_hold(hold[cur_m].valid, 1'b0, hold[cur_m].owner);
              end
              WR_UNIQ:  m_we = 1'b1;
              WR_EVICT: begin t_we = 1'b1; t_val = '0; end
              default:  ;
            endcase
          end
        end else if (gnt_rd) begin
          rd_cmd_ready[gnt_m] = 1'b1;
          load_req = 1'b1;
          st_nx    = S_RRSP;
          if (!look_bad) begin
            case (rd_op_a[gnt_m])
              RD_SHARED: if (hold[oth_m].valid && (hold[oth_m].uniq || hold[oth_m].owner)) begin
                st_nx = S_PROBE; prb_op_nx = PRB_SHARE;
              end
              RD_ONCE: if (hold[oth_m].valid && hold[oth_m].owner) begin
                st_nx = S_PROBE; prb_op_nx = PRB_SHARE;
              end
              RD_UNIQUE, RD_MKUNIQ: if (hold[oth_m].valid) begin
                st_nx = S_PROBE; prb_op_nx = PRB_INVAL;
              end
              default: ;
            endcase
            if (st_nx == S_PROBE) prb_id_nx = prb_id_q + 1'b1;
          end
        end
      end
      S_WRSP:  st_nx = S_IDLE;
      S_PROBE: if (probe_cmd_ready[oth_m]) st_nx = S_PWAIT;
      S_PWAIT: begin
        if (pw_match) begin
          wr_cmd_ready[oth_m] = 1'b1;
          m_we   = 1'b1;
          m_data = wr_data_a[oth_m];
          t_we   = 1'b1;
          t_m    = oth_m;
          t_val  = (wr_op_a[oth_m] == WR_SHARE) ? mk_hold(1'b1, 1'b0, 1'b1) : '0;
          st_nx  = S_PWRSP;
        end else if (probe_rsp_valid[oth_m]) begin
          t_we  = 1'b1;
          t_m   = oth_m;
          t_val = (prb_op_q == PRB_SHARE) ?
                  mk_hold(hold[oth_m].valid, 1'b0, hold[oth_m].owner) : '0;
          st_nx = S_RRSP;
        end
      end
      S_PWRSP: st_nx = S_RRSP;
      S_RRSP: begin
        st_nx = S_ACKW;
        if (!look_bad) begin
          case (req_op_q)
            RD_SHARED: begin
              t_we  = 1'b1;
              t_val = hold[oth_m].valid ? mk_hold(1'b1, 1'b0, 1'b0) : mk_hold(1'b1, 1'b1, 1'b1);
            end
            RD_UNIQUE, RD_MKUNIQ: begin t_we = 1'b1; t_val = mk_hold(1'b1, 1'b1, 1'b1); end
            default: ;
          endcase
        end
      end
      S_ACKW:  if (rd_ack_valid[req_m_q]) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      req_m_q    <= 1'b0;
      req_op_q   <= RD_SHARED;
      req_addr_q <= '0;
      prb_op_q   <= PRB_INVAL;
      prb_id_q   <= '0;
    end else begin
      st_q     <= st_nx;
      prb_op_q <= prb_op_nx;
      prb_id_q <= prb_id_nx;
      if (load_req) begin
        req_m_q    <= gnt_m;
        req_op_q   <= rd_op_a[gnt_m];
        req_addr_q <= look_addr;
      end
    end
  end

  // Outputs decoded from state.
  logic data_op;
  assign data_op = (req_op_q == RD_SHARED) || (req_op_q == RD_UNIQUE) || (req_op_q == RD_ONCE);

  always_comb begin
    wr_rsp_valid    = '0;
    rd_rsp_valid    = '0;
    probe_cmd_valid = '0;
    if (st_q == S_WRSP)  wr_rsp_valid[req_m_q]  = 1'b1;
    if (st_q == S_PWRSP) wr_rsp_valid[~req_m_q] = 1'b1;
    if (st_q == S_PROBE) probe_cmd_valid[~req_m_q] = 1'b1;
    if (st_q == S_RRSP)  rd_rsp_valid[req_m_q]  = 1'b1;
    rd_rsp_kind   = RSP_OK;
    rd_rsp_unique = 1'b0;
    rd_rsp_owner  = 1'b0;
    rd_rsp_dirty  = 1'b0;
    rd_rsp_data   = '0;
    if (data_op) begin
      if (look_bad) begin
        rd_rsp_kind = RSP_ERR;
      end else begin
        rd_rsp_kind = RSP_DATA;
        rd_rsp_data = m_rd;
        if (req_op_q == RD_UNIQUE ||
            (req_op_q == RD_SHARED && !hold[oth_m].valid)) begin
          rd_rsp_unique = 1'b1;
          rd_rsp_owner  = 1'b1;
        end
      end
    end
  end

  assign probe_cmd_op   = prb_op_q;
  assign probe_cmd_addr = req_addr_q;
  assign probe_cmd_id   = prb_id_q;

  // Assertions next to the control they guard.
  assert_wr_rsp_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wr_cmd_valid & wr_cmd_ready)) |=> (wr_rsp_valid != 2'b00));

  assert_probe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(probe_cmd_valid & ~probe_cmd_ready)) |=>
      ($stable(probe_cmd_valid) && $stable(probe_cmd_addr) && $stable(probe_cmd_id)));

  assert_no_rsp_in_probe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|probe_cmd_valid) |-> (rd_rsp_valid == 2'b00));

  assert_unique_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rd_rsp_valid) && rd_rsp_kind == RSP_DATA && rd_rsp_unique) |-> !hold[oth_m].valid);

  assert_wr_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rd_cmd_valid & rd_cmd_ready)) |-> (wr_cmd_valid == 2'b00));

  assert_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_rsp_valid) |=> (rd_cmd_ready == 2'b00 && wr_cmd_ready == 2'b00));

  assert_one_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_rsp_valid) && $onehot0(rd_cmd_ready));

endmodule

// File: tb/coh_hub_tb.sv
module coh_hub_tb_top;
  localparam int AW = 4, DW = 16, IDW = 3;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] rv, ack, wv, pready, prsp;
  logic [2:0] rop [2];
  logic [2:0] wop [2];
  logic [AW-1:0] radr [2];
  logic [AW-1:0] wadr [2];
  logic [DW-1:0] wdat [2];
  logic [IDW-1:0] wid [2];

  logic [1:0] rd_cmd_ready, rd_rsp_valid, rd_rsp_kind, wr_cmd_ready, wr_rsp_valid, probe_cmd_valid;
  logic [DW-1:0] rd_rsp_data;
  logic rd_rsp_unique, rd_rsp_owner, rd_rsp_dirty, probe_cmd_op;
  logic [AW-1:0] probe_cmd_addr;
  logic [IDW-1:0] probe_cmd_id;

  coh_hub #(.AW(AW), .DW(DW), .MEM_LINES(12), .IDW(IDW)) dut_i (
    .clk(clk), .arst_n(arst_n),
    .rd_cmd_valid(rv), .rd_cmd_ready(rd_cmd_ready), .rd_cmd_op({rop[1], rop[0]}),
    .rd_cmd_addr({radr[1], radr[0]}),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_kind(rd_rsp_kind), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_unique(rd_rsp_unique), .rd_rsp_owner(rd_rsp_owner), .rd_rsp_dirty(rd_rsp_dirty),
    .rd_ack_valid(ack),
    .wr_cmd_valid(wv), .wr_cmd_ready(wr_cmd_ready), .wr_cmd_op({wop[1], wop[0]}),
    .wr_cmd_addr({wadr[1], wadr[0]}), .wr_cmd_data({wdat[1], wdat[0]}), .wr_cmd_id({wid[1], wid[0]}),
    .wr_rsp_valid(wr_rsp_valid),
    .probe_cmd_valid(probe_cmd_valid), .probe_cmd_ready(pready), .probe_cmd_op(probe_cmd_op),
    .probe_cmd_addr(probe_cmd_addr), .probe_cmd_id(probe_cmd_id), .probe_rsp_valid(prsp)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Read response captured by rd_get.
  int r_kind, r_data, r_u, r_o, r_d;
  bit r_got;

  task automatic rd_send(input int m, input int op, input int addr);
    @(negedge clk);
    rv[m] = 1'b1; rop[m] = op[2:0]; radr[m] = addr[AW-1:0];
    #1;
    while (!rd_cmd_ready[m]) begin @(negedge clk); #1; end
    @(negedge clk);
    rv[m] = 1'b0;
  endtask

  task automatic rd_get(input int m);
    r_got = 0;
    for (int i = 0; i < 40; i++) begin
      if (rd_rsp_valid[m]) begin
        r_got = 1; r_kind = rd_rsp_kind; r_data = rd_rsp_data;
        r_u = rd_rsp_unique; r_o = rd_rsp_owner; r_d = rd_rsp_dirty;
        break;
      end
      @(negedge clk);
    end
    if (r_got) begin
      @(negedge clk); ack[m] = 1'b1;
      @(negedge clk); ack[m] = 1'b0;
    end else begin
      r_kind = -1; r_data = -1; r_u = -1; r_o = -1; r_d = -1;
    end
  endtask

  bit w_got;
  task automatic wr_send(input int m, input int op, input int addr, input int data, input int id);
    @(negedge clk);
    wv[m] = 1'b1; wop[m] = op[2:0]; wadr[m] = addr[AW-1:0];
    wdat[m] = data[DW-1:0]; wid[m] = id[IDW-1:0];
    #1;
    while (!wr_cmd_ready[m]) begin @(negedge clk); #1; end
    @(negedge clk);
    wv[m] = 1'b0;
    w_got = wr_rsp_valid[m];
  endtask

  int p_op, p_addr, p_id;
  bit p_got;
  task automatic prb_take(input int m);
    p_got = 0;
    for (int i = 0; i < 40; i++) begin
      if (probe_cmd_valid[m]) begin
        p_got = 1; p_op = probe_cmd_op; p_addr = probe_cmd_addr; p_id = probe_cmd_id;
        pready[m] = 1'b1;
        @(negedge clk);
        pready[m] = 1'b0;
        break;
      end
      @(negedge clk);
    end
    if (!p_got) begin p_op = -1; p_addr = -1; p_id = 0; end
  endtask

  task automatic prb_ok(input int m);
    @(negedge clk); prsp[m] = 1'b1;
    @(negedge clk); prsp[m] = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    #1;
    chk("R1 rd_cmd_ready idle", rd_cmd_ready, 0);
    chk("R1 rd_rsp_valid idle", rd_rsp_valid, 0);
    chk("R1 wr_rsp_valid idle", wr_rsp_valid, 0);
    chk("R1 probe_cmd_valid idle", probe_cmd_valid, 0);
    rd_send(0, 2, 7);
    rd_get(0);
    chk("R1 memory zero kind", r_kind, 2);
    chk("R1 memory zero data", r_data, 0);
  endtask

  task automatic t_plain();
    wr_send(0, 0, 2, 16'hA5A5, 0);
    chk("R7 writeInvalid rsp", w_got, 1);
    rd_send(1, 0, 2);
    chk("R2 no probe", probe_cmd_valid, 0);
    rd_get(1);
    chk("R2 kind", r_kind, 2);
    chk("R2 data", r_data, 16'hA5A5);
    chk("R2 unique", r_u, 1);
    chk("R2 owner", r_o, 1);
    chk("R2 dirty", r_d, 0);
  endtask

  task automatic t_share_probe();
    rd_send(0, 0, 2);
    chk("R3 no rsp before probe", rd_rsp_valid, 0);
    prb_take(1);
    chk("R3 probe op share", p_op, 1);
    chk("R3 probe addr", p_addr, 2);
    repeat (2) begin
      @(negedge clk);
      chk("R3 rsp held during probe", rd_rsp_valid, 0);
    end
    prb_ok(1);
    rd_get(0);
    chk("R3 kind", r_kind, 2);
    chk("R3 data", r_data, 16'hA5A5);
    chk("R3 unique", r_u, 0);
    chk("R3 owner", r_o, 0);
  endtask

  task automatic t_unique_wb();
    rd_send(0, 1, 2);
    prb_take(1);
    chk("R4 probe op invalidate", p_op, 0);
    wr_send(1, 0, 2, 16'h1234, p_id);
    chk("R5 writeback rsp", w_got, 1);
    rd_get(0);
    chk("R5 data after writeback", r_data, 16'h1234);
    chk("R4 unique grant", r_u, 1);
    chk("R4 owner grant", r_o, 1);
  endtask

  task automatic t_share_wb();
    rd_send(1, 0, 2);
    prb_take(0);
    chk("R3 probe share to unique holder", p_op, 1);
    wr_send(0, 1, 2, 16'h5678, p_id);
    chk("R5 writeShare rsp", w_got, 1);
    rd_get(1);
    chk("R5 data after writeShare", r_data, 16'h5678);
    chk("R3 lodger grant", r_o, 0);
  endtask

  task automatic t_mkuniq();
    rd_send(1, 3, 2);
    prb_take(0);
    chk("R4 upgrade probes invalidate", p_op, 0);
    @(negedge clk);
    wv[0] = 1'b1; wop[0] = 3'd0; wadr[0] = 4'd2; wdat[0] = 16'hDEAD; wid[0] = IDW'(p_id + 1);
    for (int i = 0; i < 3; i++) begin
      #1; chk("R5 wrong id stalls", wr_cmd_ready, 0);
      @(negedge clk);
    end
    wv[0] = 1'b0;
    prb_ok(0);
    rd_get(1);
    chk("R4 upgrade success kind", r_kind, 0);
  endtask

  task automatic t_evict();
    wr_send(1, 3, 2, 0, 0);
    chk("R7 evict rsp", w_got, 1);
    rd_send(0, 0, 2);
    rd_get(0);
    chk("R7 after evict unique", r_u, 1);
    chk("R7 after evict data kept", r_data, 16'h5678);
  endtask

  task automatic t_bad();
    rd_send(0, 1, 13);
    rd_get(0);
    chk("R6 bad unique read error", r_kind, 1);
    rd_send(1, 2, 14);
    rd_get(1);
    chk("R6 bad once read error", r_kind, 1);
    wr_send(1, 0, 13, 16'h7777, 0);
    chk("R6 bad write success", w_got, 1);
  endtask

  task automatic t_barrier();
    rd_send(1, 4, 0);
    rd_get(1);
    chk("R8 read barrier success", r_kind, 0);
    wr_send(0, 4, 0, 0, 0);
    chk("R8 write barrier success", w_got, 1);
  endtask

  task automatic t_prio();
    @(negedge clk);
    rv[0] = 1'b1; rop[0] = 3'd2; radr[0] = 4'd3;
    wv[1] = 1'b1; wop[1] = 3'd2; wadr[1] = 4'd3; wdat[1] = 16'h0BEE; wid[1] = '0;
    #1;
    chk("R9 write wins ready", wr_cmd_ready, 2'b10);
    chk("R9 read held", rd_cmd_ready, 0);
    @(negedge clk);
    wv[1] = 1'b0;
    chk("R9 write rsp", wr_rsp_valid, 2'b10);
    #1;
    while (!rd_cmd_ready[0]) begin @(negedge clk); #1; end
    @(negedge clk);
    rv[0] = 1'b0;
    rd_get(0);
    chk("R9 read sees prior write", r_data, 16'h0BEE);
    // two reads together: master 0 first
    @(negedge clk);
    rv = 2'b11; rop[0] = 3'd4; rop[1] = 3'd4;
    #1;
    chk("R9 master0 read first", rd_cmd_ready, 2'b01);
    @(negedge clk);
    rv[0] = 1'b0;
    rd_get(0);
    #1;
    while (!rd_cmd_ready[1]) begin @(negedge clk); #1; end
    @(negedge clk);
    rv[1] = 1'b0;
    rd_get(1);
    chk("R9 master1 served after", r_kind, 0);
  endtask

  task automatic t_lock();
    rd_send(0, 2, 4);
    chk("R10 response present", rd_rsp_valid, 2'b01);
    @(negedge clk);
    wv[1] = 1'b1; wop[1] = 3'd2; wadr[1] = 4'd4; wdat[1] = 16'h4444; wid[1] = '0;
    rv[1] = 1'b1; rop[1] = 3'd4;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R10 write locked", wr_cmd_ready, 0);
      chk("R10 read locked", rd_cmd_ready, 0);
      @(negedge clk);
    end
    rv[1] = 1'b0;
    ack[0] = 1'b1;
    @(negedge clk);
    ack[0] = 1'b0;
    #1;
    chk("R10 write accepted after ack", wr_cmd_ready, 2'b10);
    @(negedge clk);
    wv[1] = 1'b0;
    chk("R10 write rsp after ack", wr_rsp_valid, 2'b10);
  endtask

  task automatic t_once();
    wr_send(0, 0, 5, 16'h0C0C, 0);
    rd_send(0, 2, 5);
    rd_get(0);
    chk("R11 once data", r_data, 16'h0C0C);
    chk("R11 once not unique", r_u, 0);
    chk("R11 once not owner", r_o, 0);
    rd_send(1, 0, 5);
    chk("R11 no probe", probe_cmd_valid, 0);
    rd_get(1);
    chk("R11 other granted unique", r_u, 1);
  endtask

  initial begin
    rv = 0; ack = 0; wv = 0; pready = 0; prsp = 0;
    for (int i = 0; i < 2; i++) begin
      rop[i] = 0; wop[i] = 0; radr[i] = 0; wadr[i] = 0; wdat[i] = 0; wid[i] = 0;
    end
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain();
    t_share_probe();
    t_unique_wb();
    t_share_wb();
    t_mkuniq();
    t_evict();
    t_bad();
    t_barrier();
    t_prio();
    t_lock();
    t_once();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule